// File: doc/BRIEF.md
# UART Queue with Trigger Levels and DMA Requests

This block is the character queue that sits between a UART serial engine and the rest of the chip for one direction of traffic. It stores up to 16 bytes in arrival order, with the oldest byte always visible on the read port. It reports how full it is, and it raises a level interrupt plus two DMA request lines, a single-transfer one and a burst one, from that fill level.

Two configuration inputs set the meaning of these outputs. One selects the direction. On the receive side a request means "data is waiting". On the transmit side it means "room is available". The other selects the depth: the full 16-entry queue, or a one-byte holding register that gives classic double-buffered behaviour. A three-bit select picks the burst and interrupt threshold as a fraction of the depth.

Push, pop and configuration all share one clock. Configuration is expected to change only while the queue is empty.

Top module: `uart_qlevel_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. `pop_data` always shows the oldest stored byte without a pop, and `fill_count` equals the number of stored bytes one clock after each accepted push or pop.
- R2: In queue mode (`cfg_fifo_en`=1) `full` is high exactly when 16 bytes are stored, and `empty` is high exactly when none are stored.
- R3: A push while full is dropped: contents and count are unchanged. It also sets `ovf_flag`, which stays high until reset.
- R4: A pop while empty is ignored. The count stays 0 and the next byte pushed is the next byte popped.
- R5: In one-byte mode (`cfg_fifo_en`=0) capacity is one: `full` rises after a single accepted push.
- R6: `cfg_trig_sel` values 0, 1, 2, 3 and 4 set the threshold to 2, 4, 8, 12 and 14 entries.
- R7: `cfg_trig_sel` values 5, 6 and 7 set the threshold to 8 entries.
- R8: Receive (`cfg_dir_tx`=0) in queue mode: `dma_breq` and `lvl_irq` are high when `fill_count` is at or above the threshold.
- R9: Transmit (`cfg_dir_tx`=1) in queue mode: `dma_breq` and `lvl_irq` are high when `fill_count` is at or below the threshold.
- R10: `dma_sreq` is high when at least one byte is stored (receive), or when at least one slot is free (transmit).
- R11: In one-byte mode the threshold is ignored, and `dma_breq` and `lvl_irq` equal `dma_sreq`.
- R12: A push and a pop in the same cycle are each judged on the count before that edge. With 1 to 15 bytes stored both happen and the count is unchanged. When full only the pop happens. When empty only the push happens.
- R13: After reset the queue is empty with `fill_count`=0, and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fifo_en | input | 1 | 1 = 16-entry queue, 0 = one-byte holding register |
| cfg_dir_tx | input | 1 | 1 = transmit side, 0 = receive side |
| cfg_trig_sel | input | 3 | Threshold select |
| push | input | 1 | Write request |
| push_data | input | WIDTH (8) | Byte to write |
| pop | input | 1 | Read request |
| pop_data | output | WIDTH (8) | Oldest stored byte |
| full | output | 1 | No free slot at current capacity |
| empty | output | 1 | No stored byte |
| fill_count | output | $clog2(DEPTH)+1 (5) | Number of stored bytes |
| lvl_irq | output | 1 | Level interrupt |
| dma_sreq | output | 1 | Single-transfer DMA request |
| dma_breq | output | 1 | Burst DMA request |
| ovf_flag | output | 1 | Sticky push-while-full flag |

## Verification
Every select value, all eight of them, is swept in both directions while the queue fills from 0 to 16 and then drains. A wrong threshold table, a wrong fallback for the unused codes, or a swapped comparison shows up as the burst line changing state one or more entries away from the expected count. The bench targets the edges: a seventeenth push, a pop while empty, and same-cycle push and pop at empty, partly filled and full. A design that let a dropped push through would corrupt the byte order or overrun the count. A design that judged simultaneous requests on the updated count would drop the pop at full or the push at empty. One-byte mode is run in both directions with the select at a valid value and at an unused one. There, a design that kept applying the threshold would drive the burst line apart from the single line.

// File: rtl/uart_qf_pkg.sv
// Package: shared constants and the threshold-select decode for the UART queue.
// Assumes the depth is divisible by 8 so every fraction lands on a whole entry.
package uart_qf_pkg;

    // Threshold select codes; any other code falls back to one half.
    typedef enum logic [2:0] {
        TRIG_EIGHTH   = 3'd0,
        TRIG_QUARTER  = 3'd1,
        TRIG_HALF     = 3'd2,
        TRIG_3QUARTER = 3'd3,
        TRIG_7EIGHTHS = 3'd4
    } trig_sel_e;

    // Return the threshold in eighths of the depth for a select code.
    function automatic int unsigned trig_eighths(input logic [2:0] sel);
        case (trig_sel_e'(sel))
            TRIG_EIGHTH:   return 1;
            TRIG_QUARTER:  return 2;
            TRIG_HALF:     return 4;
            TRIG_3QUARTER: return 6;
            TRIG_7EIGHTHS: return 7;
            default:       return 4;
        endcase
    endfunction

endpackage

// File: rtl/uart_qf_store.sv
// Module: circular byte store with read/write pointers and an occupancy count.
// Capacity is supplied at run time (1..DEPTH). Acceptance of a push or pop is
// judged on the count before the edge. Oldest byte is shown on pop_data.
// Assumes capacity changes only while empty.
module uart_qf_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cap,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             overflow
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    // Advance a pointer, wrapping at the last slot for any depth.
    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests are honoured this cycle.
    always_comb begin
        full    = (count >= cap);
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // Write accepted bytes into the array.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Maintain pointers, count and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (push && !push_ok) begin
                overflow <= 1'b1;
            end
        end
    end

    // Present the oldest entry without a pop.
    assign pop_data = mem[rd_ptr];

endmodule

// File: rtl/uart_qf_level.sv
// Module: turns the three-bit select into a threshold in entries.
// The eight-entry table is built at elaboration from DEPTH, so no table is
// written by hand; codes outside the valid five map to one half.
module uart_qf_level #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [2:0]    sel,
    output logic [CW-1:0] level
);

    logic [CW-1:0] tbl [8];

    // One table slot per select code, computed from the depth.
    for (genvar g = 0; g < 8; g++) begin : g_lvl
        localparam int unsigned LV = (DEPTH * uart_qf_pkg::trig_eighths(3'(g))) / 8;
        assign tbl[g] = CW'(LV);
    end

    // Pick the slot for the current select.
    assign level = tbl[sel];

endmodule

// File: rtl/uart_qf_req.sv
// Module: request and interrupt generation from the occupancy count.
// Receive side asks for service when data waits; transmit side when room
// exists. In one-byte mode the threshold is bypassed.
module uart_qf_req #(
    parameter int CW = 5
) (
    input  logic          fifo_en,
    input  logic          dir_tx,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] level,
    output logic          sreq,
    output logic          breq,
    output logic          irq
);

    logic trig_hit;

    // Compare the count against capacity and threshold for the direction.
    always_comb begin
        sreq     = dir_tx ? (count < cap) : (count != '0);
        trig_hit = dir_tx ? (count <= level) : (count >= level);
        breq     = fifo_en ? trig_hit : sreq;
        irq      = breq;
    end

endmodule

// File: rtl/uart_qlevel_fifo.sv
// Module (top): one-direction UART byte queue with level interrupt and DMA
// single/burst requests. Single clock domain; configuration is assumed to be
// changed only while the queue is empty.
module uart_qlevel_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fifo_en,
    input  logic             cfg_dir_tx,
    input  logic [2:0]       cfg_trig_sel,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    fill_count,
    output logic             lvl_irq,
    output logic             dma_sreq,
    output logic             dma_breq,
    output logic             ovf_flag
);

    logic [CW-1:0] cap;
    logic [CW-1:0] level;

    // Effective capacity: full depth or a single holding byte.
    assign cap = cfg_fifo_en ? CW'(DEPTH) : CW'(1);

    uart_qf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (fill_count),
        .full      (full),
        .empty     (empty),
        .overflow  (ovf_flag)
    );

    uart_qf_level #(.DEPTH(DEPTH)) u_level (
        .sel   (cfg_trig_sel),
        .level (level)
    );

    uart_qf_req #(.CW(CW)) u_req (
        .fifo_en (cfg_fifo_en),
        .dir_tx  (cfg_dir_tx),
        .count   (fill_count),
        .cap     (cap),
        .level   (level),
        .sreq    (dma_sreq),
        .breq    (dma_breq),
        .irq     (lvl_irq)
    );

endmodule

// File: rtl/uart_qlevel_fifo_chk.sv
// Module: property checker for the UART queue, attached by bind below.
// Observes ports only; assumes configuration changes only while empty.
module uart_qlevel_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_fifo_en,
    input logic          cfg_dir_tx,
    input logic          push,
    input logic          pop,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] fill_count,
    input logic          dma_sreq,
    input logic          dma_breq,
    input logic          ovf_flag
);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> $stable(fill_count));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> fill_count == '0);

    assert_single_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en && empty && push |=> (cfg_fifo_en || full));

    assert_rx_burst_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo_en && !cfg_dir_tx && full |-> dma_breq);

    assert_tx_burst_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo_en && cfg_dir_tx && empty |-> dma_breq);

    assert_rx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dir_tx |-> (dma_sreq == !empty));

    assert_byte_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |-> (dma_breq == dma_sreq));

endmodule

bind uart_qlevel_fifo uart_qlevel_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_dir_tx  (cfg_dir_tx),
    .push        (push),
    .pop         (pop),
    .full        (full),
    .empty       (empty),
    .fill_count  (fill_count),
    .dma_sreq    (dma_sreq),
    .dma_breq    (dma_breq),
    .ovf_flag    (ovf_flag)
);

// File: tb/uart_qlevel_fifo_test.sv
// Bench: scoreboard queue of accepted bytes; every pop compares the design's
// head byte with the queue front, and every cycle's flags with a model.
module uart_qlevel_fifo_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_fifo_en;
    logic       cfg_dir_tx;
    logic [2:0] cfg_trig_sel;
    logic       push;
    logic [7:0] push_data;
    logic       pop;
    logic [7:0] pop_data;
    logic       full;
    logic       empty;
    logic [4:0] fill_count;
    logic       lvl_irq;
    logic       dma_sreq;
    logic       dma_breq;
    logic       ovf_flag;

    int         n_run  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    logic [7:0] sb_q[$];
    bit         exp_ovf;

    always #4 clk = ~clk;

    uart_qlevel_fifo uut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_dir_tx(cfg_dir_tx),
        .cfg_trig_sel(cfg_trig_sel), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .full(full), .empty(empty), .fill_count(fill_count),
        .lvl_irq(lvl_irq), .dma_sreq(dma_sreq), .dma_breq(dma_breq), .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Threshold per select code (R6 valid codes, R7 fallback).
    function automatic int lvl_of(input int sel);
        case (sel)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 14;
            default: return 8;
        endcase
    endfunction

    task automatic check_status();
        int  n   = sb_q.size();
        int  cap = cfg_fifo_en ? 16 : 1;
        int  lv  = lvl_of(int'(cfg_trig_sel));
        bit  sr  = cfg_dir_tx ? (n < cap) : (n > 0);
        bit  br;
        string btag;
        if (!cfg_fifo_en) begin
            br   = sr;
            btag = "R11";
        end else begin
            br   = cfg_dir_tx ? (n <= lv) : (n >= lv);
            btag = $sformatf("%s %s", cfg_dir_tx ? "R9" : "R8", cfg_trig_sel > 4 ? "R7" : "R6");
        end
        check("R1", "fill_count", int'(fill_count), n);
        check(cfg_fifo_en ? "R2" : "R5", "full", int'(full), int'(n >= cap));
        check("R2", "empty", int'(empty), int'(n == 0));
        check("R10", "dma_sreq", int'(dma_sreq), int'(sr));
        check(btag, "dma_breq", int'(dma_breq), int'(br));
        check(btag, "lvl_irq", int'(lvl_irq), int'(br));
        check("R3", "ovf_flag", int'(ovf_flag), int'(exp_ovf));
    endtask

    // Driver and monitor for one cycle; called at a falling edge.
    task automatic step(input bit p, input logic [7:0] d, input bit o);
        int n   = sb_q.size();
        int cap = cfg_fifo_en ? 16 : 1;
        if (o && n > 0) begin
            check(p ? "R12" : "R1", "pop_data", int'(pop_data), int'(sb_q[0]));
        end
        push = p; push_data = d; pop = o;
        @(posedge clk);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        if (o && n > 0) void'(sb_q.pop_front());
        if (p) begin
            if (n < cap) sb_q.push_back(d);
            else exp_ovf = 1'b1;
        end
        if (o && !p && n == 0) check("R4", "fill_count after empty pop", int'(fill_count), 0);
        if (p && o) check("R12", "fill_count after push+pop", int'(fill_count), sb_q.size());
        check_status();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; push = 1'b0; pop = 1'b0; push_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sb_q.delete();
        exp_ovf = 1'b0;
        @(negedge clk);
        check("R13", "fill_count", int'(fill_count), 0);
        check("R13", "empty", int'(empty), 1);
        check("R13", "ovf_flag", int'(ovf_flag), 0);
        check_status();
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_fifo_en = 1'b1; cfg_dir_tx = 1'b0; cfg_trig_sel = 3'd0;
        @(negedge clk);
        do_reset();

        // Sweep every select code in both directions: fill past full, drain past empty.
        for (int dir = 0; dir < 2; dir++) begin
            for (int sel = 0; sel < 8; sel++) begin
                cfg_dir_tx = dir[0]; cfg_trig_sel = sel[2:0];
                @(negedge clk);
                check_status();
                for (int i = 0; i < 17; i++) step(1'b1, 8'((dir << 7) | (sel << 4) | i), 1'b0);
                for (int i = 0; i < 17; i++) step(1'b0, 8'h00, 1'b1);
                do_reset();   // R3: only reset clears the sticky flag
            end
        end

        // R12: simultaneous push and pop at partial, full and empty.
        cfg_dir_tx = 1'b0; cfg_trig_sel = 3'd2;
        for (int i = 0; i < 5; i++) step(1'b1, 8'(8'hA0 + i), 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 8'(8'hB0 + i), 1'b1);
        for (int i = 0; i < 11; i++) step(1'b1, 8'(8'hC0 + i), 1'b0);
        step(1'b1, 8'hEE, 1'b1);
        while (sb_q.size() > 0) step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'h5A, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        do_reset();

        // R4: pop on empty then push; the pushed byte must come out next.
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'h3C, 1'b0);
        step(1'b0, 8'h00, 1'b1);

        // R5 and R11: one-byte mode, both directions, valid and fallback selects.
        cfg_fifo_en = 1'b0;
        for (int dir = 0; dir < 2; dir++) begin
            for (int k = 0; k < 2; k++) begin
                cfg_dir_tx = dir[0]; cfg_trig_sel = k ? 3'd7 : 3'd0;
                @(negedge clk);
                check_status();
                step(1'b1, 8'(8'h60 + dir * 2 + k), 1'b0);
                step(1'b1, 8'hFF, 1'b0);
                step(1'b0, 8'h00, 1'b1);
                step(1'b0, 8'h00, 1'b1);
                do_reset();
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule